// File: doc/BRIEF.md
# Both-Edge Binary Counter

This block is a free-running binary counter whose value advances by one on every transition of its clock, rising and falling alike, while every storage element in it reacts to one clock edge only. It suits designs that need a count at twice the clock rate without a doubled clock and without flip-flops that trigger on both edges.

Two register banks hold the count. One bank updates on rising edges and the other on falling edges. Each bank loads the value of the opposite bank plus one. The clock level then selects which bank reaches the output: the rising bank during the high phase and the falling bank during the low phase. A synchronous clear is sampled by each bank on its own edge. The width is a parameter, and the count wraps around at the top of its range.

Top module: `twin_edge_counter`

## Requirements
- R1: At a rising clock edge where clear is low, the output becomes the value it showed during the preceding low phase plus one, and it holds that value through the high phase.
- R2: At a falling clock edge where clear is low, the output becomes the value it showed during the preceding high phase plus one, and it holds that value through the low phase.
- R3: The output does not change between two consecutive clock edges, even when clear changes during that phase.
- R4: Clear is active high and is sampled on each edge by the bank for that edge. A clear seen at a single edge, rising or falling, makes the output zero for the phase that follows that edge.
- R5: While clear is held high across both a rising and a falling edge, the output is zero after each of those edges.
- R6: The count is WIDTH bits wide (default 8) and wraps from 2^WIDTH-1 to zero on the next edge without clear.
- R7: On the first edge without clear after a cleared edge, the output is one, and it keeps rising by exactly one per edge after that.
- R8: Every storage element is updated on one clock edge polarity only; no register is written on both edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both of its edges advance the count, and its level selects the output bank |
| clr | input | 1 | Synchronous clear, active high, sampled at each edge by the bank for that edge |
| count | output | WIDTH | Current count |

## Verification
The two functions that can fall on the same edge are the clear of one bank and the increment of the other bank, which loads from the bank just cleared. The bench pulses clear so that it is seen at only one rising edge, and in a separate case at only one falling edge, while the count is running. It then expects zero after that edge and one after the next edge. A reference count that resets on any cleared edge and otherwise adds one judges every edge, and the bench also checks the value again late in each phase to show it held. A long run without clear carries the count through the wrap point twice.

// File: rtl/twin_edge_pkg.sv
package twin_edge_pkg;

  // Which clock edge updates a register bank.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;

endpackage

// File: rtl/edge_bank.sv
module edge_bank
  import twin_edge_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter edge_pol_e   POL   = EDGE_RISE
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] peer,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] next_q;

  // Load the opposite bank plus one, or zero on clear.
  always_comb begin
    if (clr) next_q = '0;
    else     next_q = peer + ONE;
  end

  // The parameter picks a single edge polarity for this bank (R8).
  generate
    if (POL == EDGE_RISE) begin : g_rise
      always_ff @(posedge clk) begin
        q <= next_q;
      end
    end else begin : g_fall
      always_ff @(negedge clk) begin
        q <= next_q;
      end
    end
  endgenerate

endmodule

// File: rtl/phase_mux.sv
module phase_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             sel_hi,
  input  logic [WIDTH-1:0] hi_val,
  input  logic [WIDTH-1:0] lo_val,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    if (sel_hi) y = hi_val;
    else        y = lo_val;
  end

endmodule

// File: rtl/twin_edge_counter.sv
module twin_edge_counter
  import twin_edge_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] rise_q;
  logic [WIDTH-1:0] fall_q;

  // Rising bank follows the falling bank (R1).
  edge_bank #(
    .WIDTH (WIDTH),
    .POL   (EDGE_RISE)
  ) u_rise_bank (
    .clk  (clk),
    .clr  (clr),
    .peer (fall_q),
    .q    (rise_q)
  );

  // Falling bank follows the rising bank (R2).
  edge_bank #(
    .WIDTH (WIDTH),
    .POL   (EDGE_FALL)
  ) u_fall_bank (
    .clk  (clk),
    .clr  (clr),
    .peer (rise_q),
    .q    (fall_q)
  );

  // Clock level chooses the bank that updated most recently.
  phase_mux #(
    .WIDTH (WIDTH)
  ) u_out_mux (
    .sel_hi (clk),
    .hi_val (rise_q),
    .lo_val (fall_q),
    .y      (count)
  );

endmodule

// File: rtl/twin_edge_counter_chk.sv
module twin_edge_counter_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             clr,
  input logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] TWO = WIDTH'(2);

  logic armed       = 1'b0;
  logic clr_at_rise = 1'b0;
  logic clr_at_fall = 1'b0;

  always_ff @(posedge clk) begin
    clr_at_rise <= clr;
    if (clr) armed <= 1'b1;
  end

  always_ff @(negedge clk) begin
    clr_at_fall <= clr;
  end

  // R1 R2 R6: high-phase values advance by two per clock period
  high_step_chk: assert property (@(negedge clk) disable iff (!armed)
    (!clr_at_rise && !clr_at_fall) |-> (count == $past(count) + TWO));

  // R1 R2 R6: low-phase values advance by two per clock period
  low_step_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr_at_rise && !clr_at_fall) |-> (count == $past(count) + TWO));

  // R4 R5: clear at a rising edge zeroes the high phase
  rise_clear_chk: assert property (@(negedge clk) disable iff (!armed)
    clr_at_rise |-> (count == '0));

  // R4 R5: clear at a falling edge zeroes the low phase
  fall_clear_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_at_fall |-> (count == '0));

endmodule

bind twin_edge_counter twin_edge_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .clr   (clr),
  .count (count)
);

// File: tb/tb_twin_edge_counter.sv
module tb_twin_edge_counter;

  localparam int unsigned WIDTH  = 8;
  localparam int          PERIOD = 10;
  localparam int          HALF   = PERIOD / 2;

  typedef struct {
    logic [WIDTH-1:0] val;
    string            req;
  } exp_item_t;

  logic             clk = 1'b0;
  logic             clr = 1'b1;
  logic [WIDTH-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  exp_item_t        sb_q[$];
  logic [WIDTH-1:0] ref_cnt  = '0;
  bit               prev_clr = 1'b0;

  twin_edge_counter #(.WIDTH(WIDTH)) dut (
    .clk   (clk),
    .clr   (clr),
    .count (count)
  );

  always #HALF clk = ~clk;

  // Driver: set clear mid-phase, wait for one edge, push the expectation.
  task automatic drive_edge(input bit c);
    exp_item_t it;
    #2;
    clr = c;
    @(clk);
    if (c) begin
      ref_cnt = '0;
      it.req  = prev_clr ? "R5" : "R4";
    end else begin
      ref_cnt = ref_cnt + WIDTH'(1);
      if (ref_cnt == '0)  it.req = "R6";
      else if (prev_clr)  it.req = "R7";
      else if (clk)       it.req = "R1";
      else                it.req = "R2";
    end
    it.val   = ref_cnt;
    prev_clr = c;
    sb_q.push_back(it);
  endtask

  task automatic run(input int n, input bit c);
    for (int i = 0; i < n; i++) drive_edge(c);
  endtask

  // Monitor: compare after each edge and again late in the phase (R3).
  initial begin
    exp_item_t it;
    forever begin
      @(clk);
      #1;
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        checks++;
        if (count !== it.val) begin
          errors++;
          $display("FAIL %s: count=%0d expected=%0d at %0t", it.req, count, it.val, $time);
        end
        #3;
        checks++;
        if (count !== it.val) begin
          errors++;
          $display("FAIL R3: count=%0d expected=%0d late in phase at %0t", count, it.val, $time);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired expected=finish at %0t", $time);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    run(4, 1'b1);            // R4 R5: reset state with clear over both edges
    run(20, 1'b0);           // R7 R1 R2: count from one
    run(1, 1'b1);            // R4: clear at a rising edge only
    run(7, 1'b0);
    run(1, 1'b0);
    run(1, 1'b1);            // R4: clear at a falling edge only
    run(2 * (1 << WIDTH) + 10, 1'b0);  // R6: wrap twice
    run(2, 1'b1);            // R5: clear held again
    run(6, 1'b0);
    @(clk);
    #5;
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule